// File: doc/BRIEF.md
# Page-Buffered Program and Data Store Target

This block is the target end of an in-system programming path. A host issues one command per cycle on a simple command port. The block holds two nonvolatile-style stores. The first is a word-organised program store that is written a whole page at a time. The second is a byte-organised data store that is written one byte per command. Program words are first staged, byte by byte, in a page buffer. A page-write command then copies the whole buffer into one page of the program store.

Every write keeps the block busy for a fixed number of clock cycles. During that time, a read of a location that is being written returns 0xFF. A host can therefore poll with reads until the programmed value appears. For a value of 0xFF it must instead wait out the full write time. Any command other than a read that arrives while a write is in progress is dropped and reported as a collision. The two stores power up in the erased state, all bytes 0xFF.

Top module: `isp_nvm_target`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `err_collide` and `err_order` are low, and every byte of both stores reads as 0xFF.
- R2: Command codes on `cmd_op` are: 0 load low byte, 1 load high byte, 2 write page, 3 write data byte, 4 read program low byte, 5 read program high byte, 6 read data byte, 7 no operation. A read accepted at one clock edge gives `rsp_valid` high and the byte on `rsp_data` after that same edge, for one cycle. Code 7 changes no output and no store.
- R3: Load commands place `cmd_data` into the buffer slot chosen by the low OFF_W bits of `cmd_addr`. A high-byte load to a slot that has had no low-byte load since the last page write is ignored, and `err_order` pulses for one cycle.
- R4: A write-page command copies every buffer slot into the program page chosen by the upper PAGE_W bits of `cmd_addr`. After that, every slot of the buffer holds 0xFFFF and counts as not yet loaded.
- R5: After an accepted write-page command, `busy` is high for exactly WAIT_FLASH cycles. After an accepted write-data command, it is high for exactly WAIT_EEPROM cycles.
- R6: While a page write is in progress, a program read of any address inside that page returns 0xFF. A read in the first cycle after `busy` falls returns the new value. Program reads outside the page return the stored contents.
- R7: A data-byte write replaces the old byte completely, whatever bits it held. A read of that byte during the write returns 0xFF, and reads of other data bytes return their stored values.
- R8: A load or write command issued while `busy` is high has no effect on either store or on the buffer, and `err_collide` pulses for one cycle. Reads issued while `busy` is high do not raise `err_collide`.
- R9: Writing 0xFF to a data byte leaves it reading 0xFF once the full write time has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | OFF_W+PAGE_W | Word address for program commands; its low DATA_AW bits are the data-store byte address |
| cmd_data | input | 8 | Byte to load or to write |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 8 | Read response byte |
| busy | output | 1 | A write is in progress |
| err_collide | output | 1 | A non-read command arrived during a write and was dropped |
| err_order | output | 1 | A high byte was loaded before its low byte and was dropped |

## Verification
A poll read and the end of a write fall in the same cycle when a host reads every cycle during a write. The bench does this and checks three things. The read sampled in the last busy cycle must still return 0xFF. The read one cycle later must return the new value. The number of 0xFF responses must equal the write time exactly. A command collision is provoked by issuing loads and writes between poll reads of an active write. The bench judges it by the error pulse and by later reads showing that neither the buffer nor the stores were touched.

// File: rtl/isp_nvm_pkg.sv
package isp_nvm_pkg;

  typedef enum logic [2:0] {
    OP_LOAD_LO    = 3'd0,
    OP_LOAD_HI    = 3'd1,
    OP_WR_PAGE    = 3'd2,
    OP_WR_DATA    = 3'd3,
    OP_RD_PROG_LO = 3'd4,
    OP_RD_PROG_HI = 3'd5,
    OP_RD_DATA    = 3'd6,
    OP_NOP        = 3'd7
  } isp_op_e;

  typedef enum logic {
    WK_PAGE = 1'b0,
    WK_BYTE = 1'b1
  } wr_kind_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  function automatic logic op_is_read(input logic [2:0] op);
    return (op == OP_RD_PROG_LO) || (op == OP_RD_PROG_HI) || (op == OP_RD_DATA);
  endfunction

  function automatic logic op_is_mutating(input logic [2:0] op);
    return !op_is_read(op) && (op != OP_NOP);
  endfunction

endpackage

// File: rtl/isp_page_buffer.sv
module isp_page_buffer #(
  parameter int OFF_W = 4,
  localparam int SLOTS = 1 << OFF_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_lo,
  input  logic                       load_hi,
  input  logic [OFF_W-1:0]           slot,
  input  logic [7:0]                 byte_in,
  input  logic                       clear,
  output logic [SLOTS-1:0][15:0]     words,
  output logic                       order_bad
);

  logic [SLOTS-1:0] lo_seen;

  // a high byte is only taken after the low byte of the same slot
  assign order_bad = load_hi && !lo_seen[slot];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      words   <= '1;
      lo_seen <= '0;
    end else begin
      if (load_lo) begin
        words[slot][7:0] <= byte_in;
        lo_seen[slot]    <= 1'b1;
      end
      if (load_hi && lo_seen[slot]) begin
        words[slot][15:8] <= byte_in;
      end
    end
  end

endmodule

// File: rtl/isp_prog_store.sv
module isp_prog_store #(
  parameter int OFF_W  = 4,
  parameter int PAGE_W = 4,
  localparam int AW    = OFF_W + PAGE_W,
  localparam int WORDS = 1 << AW,
  localparam int SLOTS = 1 << OFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [PAGE_W-1:0]      commit_page,
  input  logic [SLOTS-1:0][15:0] page_words,
  input  logic [AW-1:0]          rd_addr,
  output logic [15:0]            rd_word
);

  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= 16'hFFFF;
    end else if (commit) begin
      for (int s = 0; s < SLOTS; s++) mem[{commit_page, OFF_W'(s)}] <= page_words[s];
    end
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/isp_data_store.sv
module isp_data_store #(
  parameter int DATA_AW = 6,
  localparam int BYTES  = 1 << DATA_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase,
  input  logic               program_now,
  input  logic [DATA_AW-1:0] addr,
  input  logic [7:0]         byte_in,
  input  logic [DATA_AW-1:0] rd_addr,
  output logic [7:0]         rd_byte
);

  logic [7:0]         mem [BYTES];
  logic [DATA_AW-1:0] pend_addr;
  logic [7:0]         pend_byte;

  // erase at the start of the write, store the new byte at its end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BYTES; b++) mem[b] <= 8'hFF;
      pend_addr <= '0;
      pend_byte <= 8'hFF;
    end else if (erase) begin
      mem[addr] <= 8'hFF;
      pend_addr <= addr;
      pend_byte <= byte_in;
    end else if (program_now) begin
      mem[pend_addr] <= pend_byte;
    end
  end

  assign rd_byte = mem[rd_addr];

endmodule

// File: rtl/isp_write_timer.sv
module isp_write_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (busy) cnt <= cnt - CNT_W'(1);
  end

endmodule

// File: rtl/isp_nvm_target.sv
module isp_nvm_target
  import isp_nvm_pkg::*;
#(
  parameter int OFF_W       = 4,
  parameter int PAGE_W      = 4,
  parameter int DATA_AW     = 6,
  parameter int WAIT_FLASH  = 40,
  parameter int WAIT_EEPROM = 20,
  localparam int PROG_AW    = OFF_W + PAGE_W,
  localparam int SLOTS      = 1 << OFF_W,
  localparam int WAIT_MAX   = (WAIT_FLASH > WAIT_EEPROM) ? WAIT_FLASH : WAIT_EEPROM,
  localparam int CNT_W      = $clog2(WAIT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [PROG_AW-1:0] cmd_addr,
  input  logic [7:0]         cmd_data,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               busy,
  output logic               err_collide,
  output logic               err_order
);

  function automatic logic [PAGE_W-1:0] page_of(input logic [PROG_AW-1:0] a);
    return a[PROG_AW-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] slot_of(input logic [PROG_AW-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [DATA_AW-1:0] byte_of(input logic [PROG_AW-1:0] a);
    return a[DATA_AW-1:0];
  endfunction

  // named internal events
  logic is_rd, accept, collide;
  logic do_load_lo, do_load_hi, start_page, start_byte;
  logic timer_done, order_bad, poll_hit;
  logic [SLOTS-1:0][15:0] buf_words;
  logic buf_all_erased;
  logic [15:0] prog_word;
  logic [7:0]  data_byte, rd_value;

  wr_kind_e          kind_q;
  logic [PAGE_W-1:0] busy_page_q;
  logic [DATA_AW-1:0] busy_byte_q;

  assign is_rd      = cmd_valid && op_is_read(cmd_op);
  assign accept     = cmd_valid && op_is_mutating(cmd_op) && !busy;
  assign collide    = cmd_valid && op_is_mutating(cmd_op) && busy;
  assign do_load_lo = accept && (cmd_op == OP_LOAD_LO);
  assign do_load_hi = accept && (cmd_op == OP_LOAD_HI);
  assign start_page = accept && (cmd_op == OP_WR_PAGE);
  assign start_byte = accept && (cmd_op == OP_WR_DATA);
  assign buf_all_erased = &buf_words;

  isp_page_buffer #(.OFF_W(OFF_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_lo  (do_load_lo),
    .load_hi  (do_load_hi),
    .slot     (slot_of(cmd_addr)),
    .byte_in  (cmd_data),
    .clear    (start_page),
    .words    (buf_words),
    .order_bad(order_bad)
  );

  isp_prog_store #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_prog (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (start_page),
    .commit_page(page_of(cmd_addr)),
    .page_words (buf_words),
    .rd_addr    (cmd_addr),
    .rd_word    (prog_word)
  );

  isp_data_store #(.DATA_AW(DATA_AW)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase      (start_byte),
    .program_now(timer_done && (kind_q == WK_BYTE)),
    .addr       (byte_of(cmd_addr)),
    .byte_in    (cmd_data),
    .rd_addr    (byte_of(cmd_addr)),
    .rd_byte    (data_byte)
  );

  isp_write_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_page || start_byte),
    .load_val(start_page ? CNT_W'(WAIT_FLASH) : CNT_W'(WAIT_EEPROM)),
    .busy    (busy),
    .done    (timer_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q      <= WK_PAGE;
      busy_page_q <= '0;
      busy_byte_q <= '0;
    end else if (start_page) begin
      kind_q      <= WK_PAGE;
      busy_page_q <= page_of(cmd_addr);
    end else if (start_byte) begin
      kind_q      <= WK_BYTE;
      busy_byte_q <= byte_of(cmd_addr);
    end
  end

  // a read that targets the location under write sees the erased pattern
  always_comb begin
    poll_hit = 1'b0;
    if (busy && is_rd) begin
      if (kind_q == WK_PAGE && cmd_op != OP_RD_DATA)
        poll_hit = (page_of(cmd_addr) == busy_page_q);
      else if (kind_q == WK_BYTE && cmd_op == OP_RD_DATA)
        poll_hit = (byte_of(cmd_addr) == busy_byte_q);
    end
  end

  always_comb begin
    case (cmd_op)
      OP_RD_PROG_LO: rd_value = prog_word[7:0];
      OP_RD_PROG_HI: rd_value = prog_word[15:8];
      default:       rd_value = data_byte;
    endcase
    if (poll_hit) rd_value = ERASED_BYTE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= ERASED_BYTE;
      err_collide <= 1'b0;
      err_order   <= 1'b0;
    end else begin
      rsp_valid   <= is_rd;
      rsp_data    <= is_rd ? rd_value : rsp_data;
      err_collide <= collide;
      err_order   <= order_bad;
    end
  end

endmodule

// File: rtl/isp_nvm_target_chk.sv
module isp_nvm_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       busy,
  input logic       err_collide,
  input logic       poll_hit,
  input logic       start_page,
  input logic       buf_all_erased,
  input logic       timer_done
);

  AST_RSP_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(cmd_valid) && ($past(cmd_op) inside {3'd4, 3'd5, 3'd6}))); // R2

  AST_POLL_RETURNS_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(poll_hit)) |-> (rsp_data == 8'hFF)); // R6

  AST_BUSY_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_valid) && ($past(cmd_op) inside {3'd2, 3'd3}))); // R5

  AST_COLLIDE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    err_collide |-> $past(busy)); // R8

  AST_BUFFER_ERASED_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_page |=> buf_all_erased); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    timer_done |=> !busy); // R5

endmodule

bind isp_nvm_target isp_nvm_target_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .rsp_valid     (rsp_valid),
  .rsp_data      (rsp_data),
  .busy          (busy),
  .err_collide   (err_collide),
  .poll_hit      (poll_hit),
  .start_page    (start_page),
  .buf_all_erased(buf_all_erased),
  .timer_done    (timer_done)
);

// File: tb/isp_nvm_target_tb_top.sv
module isp_nvm_target_tb_top;

  localparam int OFF_W = 4;
  localparam int PAGE_W = 4;
  localparam int DATA_AW = 6;
  localparam int WF = 40;
  localparam int WE = 20;
  localparam int AW = OFF_W + PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd7;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic rsp_valid, busy, err_collide, err_order;
  logic [7:0] rsp_data;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  isp_nvm_target #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_AW(DATA_AW),
                   .WAIT_FLASH(WF), .WAIT_EEPROM(WE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .err_collide(err_collide),
    .err_order(err_order)
  );

  function automatic logic [AW-1:0] waddr(input int page, input int slot);
    return AW'(page * (1 << OFF_W) + slot);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic rd(input logic [2:0] op, input logic [AW-1:0] a, output logic [7:0] v);
    send(op, a, 8'h00);
    if (!rsp_valid) begin
      n_tests++; n_fail++;
      $display("FAIL R2: rsp_valid actual 0 expected 1");
    end
    v = rsp_data;
  endtask

  task automatic idle_until_free();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 busy", busy, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 err", {err_collide, err_order}, 0);
    rd(3'd4, waddr(2, 3), v); check("R1 prog lo", v, 8'hFF);
    rd(3'd5, waddr(15, 15), v); check("R1 prog hi", v, 8'hFF);
    rd(3'd6, AW'(33), v); check("R1 data", v, 8'hFF);
  endtask

  task automatic t_nop();
    logic [7:0] v;
    send(3'd7, waddr(1, 1), 8'h12);
    check("R2 nop rsp", rsp_valid, 0);
    check("R2 nop busy/err", {busy, err_collide, err_order}, 0);
    rd(3'd4, waddr(1, 1), v); check("R2 nop store", v, 8'hFF);
  endtask

  task automatic t_page_poll();
    logic [7:0] v;
    int j;
    for (int s = 0; s < 16; s++) begin
      send(3'd0, waddr(3, s), 8'(8'h10 + s));
      send(3'd1, waddr(3, s), 8'(8'hA0 + s));
    end
    send(3'd2, waddr(3, 0), 8'h00);
    check("R5 busy after page write", busy, 1);
    j = 0;
    v = 8'hFF;
    while (v == 8'hFF && j < WF + 10) begin
      j++;
      rd(3'd4, waddr(3, 5), v);
    end
    check("R6 first good poll index", j, WF + 1);
    check("R6 polled value", v, 8'h15);
    check("R5 busy low after page", busy, 0);
    for (int s = 0; s < 16; s++) begin
      rd(3'd5, waddr(3, s), v); check("R4 page hi byte", v, 8'hA0 + s);
    end
  endtask

  task automatic t_page_isolation();
    logic [7:0] v;
    send(3'd0, waddr(5, 0), 8'h33);
    send(3'd1, waddr(5, 0), 8'h44);
    send(3'd2, waddr(5, 9), 8'h00);
    rd(3'd5, waddr(3, 2), v); check("R6 other page during write", v, 8'hA2);
    rd(3'd5, waddr(5, 0), v); check("R6 own page during write", v, 8'hFF);
    check("R8 read no collide", err_collide, 0);
    idle_until_free();
    rd(3'd5, waddr(5, 0), v); check("R4 committed hi", v, 8'h44);
    rd(3'd4, waddr(5, 1), v); check("R4 unloaded slot", v, 8'hFF);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    send(3'd0, waddr(6, 0), 8'h77);
    send(3'd1, waddr(6, 0), 8'h88);
    send(3'd2, waddr(6, 0), 8'h00);
    send(3'd0, waddr(7, 1), 8'h99);
    check("R8 load during write", err_collide, 1);
    send(3'd3, AW'(20), 8'h42);
    check("R8 data write during write", err_collide, 1);
    rd(3'd4, waddr(6, 0), v);
    check("R8 poll no collide", err_collide, 0);
    idle_until_free();
    rd(3'd6, AW'(20), v); check("R8 dropped data write", v, 8'hFF);
    send(3'd2, waddr(7, 0), 8'h00);
    idle_until_free();
    rd(3'd4, waddr(7, 1), v); check("R8 dropped load / R4 buffer cleared", v, 8'hFF);
    rd(3'd4, waddr(6, 0), v); check("R8 page survives collision", v, 8'h77);
  endtask

  task automatic t_order();
    logic [7:0] v;
    send(3'd1, waddr(8, 2), 8'h55);
    check("R3 high before low flagged", err_order, 1);
    send(3'd0, waddr(8, 3), 8'h01);
    send(3'd1, waddr(8, 3), 8'h02);
    check("R3 ordered load not flagged", err_order, 0);
    send(3'd2, waddr(8, 0), 8'h00);
    idle_until_free();
    rd(3'd5, waddr(8, 2), v); check("R3 dropped high byte", v, 8'hFF);
    rd(3'd4, waddr(8, 3), v); check("R3 slot low", v, 8'h01);
    rd(3'd5, waddr(8, 3), v); check("R3 slot high", v, 8'h02);
  endtask

  task automatic t_data();
    logic [7:0] v;
    int j, n;
    send(3'd3, AW'(10), 8'h3C);
    idle_until_free();
    send(3'd3, AW'(9), 8'h5A);
    rd(3'd6, AW'(10), v); check("R7 other byte during write", v, 8'h3C);
    j = 1;
    v = 8'hFF;
    while (v == 8'hFF && j < WE + 10) begin
      j++;
      rd(3'd6, AW'(9), v);
    end
    check("R7 first good poll index", j, WE + 1);
    check("R7 polled value", v, 8'h5A);
    send(3'd3, AW'(9), 8'hA5);
    idle_until_free();
    rd(3'd6, AW'(9), v); check("R7 overwrite replaces bits", v, 8'hA5);
    send(3'd3, AW'(9), 8'hFF);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check("R5 byte busy length", n, WE);
    rd(3'd6, AW'(9), v); check("R9 ff after full wait", v, 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nop();
    t_page_poll();
    t_page_isolation();
    t_collide();
    t_order();
    t_data();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule